// File: doc/BRIEF.md
# Run Control Sequence Launcher

This block starts special microcode sequences that do not belong to any instruction, such as the operations behind front-panel switches. It takes up to `NUM_REQ` request lines that arrive with no fixed timing. Each line passes through a chain of `SYNC_STAGES` flops clocked by the free-running bit clock. A line that has passed through the chain while the machine is idle is held in a pending register. When at least one request is pending, a fixed-priority encoder picks the pending request with the lowest index. The block places that index in the low bits of a fixed microcode entry address, and the start chain begins.

The start chain is a small three-state machine: idle, start and run. When a launch is accepted, the start strobe is high for exactly one bit-clock period, and the run flag is set on the next edge. Because the instruction register is clocked from the bit clock and not from a run-gated clock, it can load the entry address during the strobe, before RUN is high. The block also gates the machine's normal running-only instruction-register load with RUN. A halt input ends the sequence. After a halt, a request that is still pending starts its own sequence.

Top module: `seq_launcher`

## Requirements
- R1: While `rst_n` is low at a rising edge, all pending requests, the synchroniser flops and the chain are cleared. After reset, `start_strobe_o`, `run_o` and `ir_load_o` are 0 and `entry_addr_o` is 0.
- R2: Every request line passes through `SYNC_STAGES` flops and then the pending register before it is used. Take a one-cycle request pulse first sampled at edge 1 while the block is idle. `start_strobe_o` is still 0 after edge `SYNC_STAGES+1` and is 1 after edge `SYNC_STAGES+2`.
- R3: Among pending requests, the lowest index wins. `entry_addr_o` takes the upper `UADDR_W-2` bits of `ENTRY_BASE` followed by the 2-bit winning index in bits [1:0]. With the defaults this is 0x300 plus the index. The address is loaded on the same edge that raises the strobe.
- R4: `start_strobe_o` is high for exactly one cycle. If halt is low in that cycle, `run_o` rises on the next edge. The strobe and RUN are never high together.
- R5: A pending request is cleared when it launches. Other pending requests stay held, and the next one launches on the edge after RUN falls.
- R6: A request that passes through the synchroniser while the strobe or RUN is high is discarded. It does not launch after the machine returns to idle.
- R7: `halt_i` high at an edge while RUN is high clears RUN on that edge. `halt_i` high during the strobe cycle stops RUN from being set.
- R8: `ir_load_o` is high during the strobe cycle. It also follows `instr_fetch_i` while RUN is high, and is 0 while idle whatever `instr_fetch_i` does.
- R9: `entry_addr_o` changes only on an edge that raises the strobe. Between launches it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_req_i | input | NUM_REQ | Asynchronous sequence-start requests; index 0 has the highest priority |
| halt_i | input | 1 | End-of-sequence / halt; clears RUN |
| instr_fetch_i | input | 1 | Normal instruction-register load request, acted on only while running |
| entry_addr_o | output | UADDR_W | Microcode entry address of the launched sequence |
| start_strobe_o | output | 1 | One-cycle start pulse |
| ir_load_o | output | 1 | Instruction-register load enable |
| run_o | output | 1 | RUN flag |

## Verification
The bench uses the defaults: four request lines, two synchroniser stages, a 10-bit address and a base of 0x300. With these values, every entry address from 0x300 to 0x303 can be reached by draining a full set of simultaneous requests one halt at a time. The two-stage latency is exact, so the bench can confirm that the strobe is absent one edge early and present on the expected edge. The bench also halts during the strobe and sends requests while running, to check the discard and halt-priority paths.

// File: rtl/seqlaunch_pkg.sv
// Package: shared types for the sequence launcher.
// Assumes: nothing beyond IEEE 1800-2017.
package seqlaunch_pkg;

    // States of the start chain: idle, one-cycle start strobe, running.
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_START = 2'd1,
        CH_RUN   = 2'd2
    } chain_state_t;

endpackage

// File: rtl/seq_req_sync.sv
// Module: seq_req_sync
// Passes each asynchronous request line through SYNC_STAGES flops on the
// bit clock. Assumes SYNC_STAGES >= 1 and a synchronous active-low reset.
module seq_req_sync #(
    parameter int NUM_REQ     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_async_i,
    output logic [NUM_REQ-1:0] req_sync_o
);

    logic [NUM_REQ-1:0] stage_q [SYNC_STAGES];

    genvar s;
    generate
        for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw request lines.
                always_ff @(posedge clk_i) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= req_async_i;
                end
            end else begin : g_next
                // Later stages shift the sampled value along the chain.
                always_ff @(posedge clk_i) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign req_sync_o = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/seq_req_hold.sv
// Module: seq_req_hold
// Holds synchronised requests as pending bits. New bits are taken only while
// the chain is idle; the granted bit is cleared on the launch edge.
// Assumes grant_i is one-hot or zero.
module seq_req_hold #(
    parameter int NUM_REQ = 4
) (
    input  logic               clk_i,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_sync_i,
    input  logic               accept_i,
    input  logic               launch_i,
    input  logic [NUM_REQ-1:0] grant_i,
    output logic [NUM_REQ-1:0] pending_o
);

    logic [NUM_REQ-1:0] pending_q;
    logic [NUM_REQ-1:0] set_mask;
    logic [NUM_REQ-1:0] clr_mask;

    // Build the set and clear masks for this cycle.
    always_comb begin
        set_mask = accept_i ? req_sync_i : '0;
        clr_mask = launch_i ? grant_i    : '0;
    end

    // Update the pending bits; clearing wins over setting.
    always_ff @(posedge clk_i) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= (pending_q | set_mask) & ~clr_mask;
    end

    assign pending_o = pending_q;

endmodule

// File: rtl/seq_prio_enc.sv
// Module: seq_prio_enc
// Fixed-priority encoder: the lowest set index wins. Gives the index, a
// one-hot grant and a valid flag. Purely combinational.
module seq_prio_enc #(
    parameter int NUM_REQ = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_REQ-1:0] pending_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [NUM_REQ-1:0] grant_o
);

    // Scan from the highest index down so the lowest set index stays.
    always_comb begin
        valid_o = |pending_i;
        idx_o   = '0;
        grant_o = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (pending_i[i]) begin
                idx_o   = IDX_W'(i);
                grant_o = NUM_REQ'(1) << i;
            end
        end
    end

endmodule

// File: rtl/seq_start_chain.sv
// Module: seq_start_chain
// Start chain: on an accepted launch it gives a one-cycle strobe, then sets
// RUN. It registers the entry address on the launch edge, clears RUN on
// halt, and gates running-only IR loads with RUN.
// Assumes: free-running bit clock, synchronous active-low reset.
module seq_start_chain
    import seqlaunch_pkg::*;
#(
    parameter int             IDX_W      = 2,
    parameter int             UADDR_W    = 10,
    parameter logic [UADDR_W-1:0] ENTRY_BASE = 10'h300
) (
    input  logic               clk_i,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               halt_i,
    input  logic               instr_fetch_i,
    output logic               idle_o,
    output logic               launch_o,
    output logic [UADDR_W-1:0] entry_addr_o,
    output logic               strobe_o,
    output logic               run_o,
    output logic               ir_load_o
);

    chain_state_t       state_q;
    chain_state_t       state_d;
    logic [UADDR_W-1:0] entry_q;

    // Decode the idle window and whether a launch is taken this cycle.
    always_comb begin
        idle_o   = (state_q == CH_IDLE);
        launch_o = idle_o && valid_i;
    end

    // Next-state logic for the start chain.
    always_comb begin
        state_d = state_q;
        case (state_q)
            CH_IDLE:  if (valid_i) state_d = CH_START;
            CH_START: state_d = halt_i ? CH_IDLE : CH_RUN;
            CH_RUN:   if (halt_i) state_d = CH_IDLE;
            default:  state_d = CH_IDLE;
        endcase
    end

    // State register of the chain.
    always_ff @(posedge clk_i) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Load the entry address on the edge that starts the strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_n)        entry_q <= '0;
        else if (launch_o) entry_q <= {ENTRY_BASE[UADDR_W-1:IDX_W], idx_i};
    end

    // Drive the outputs; the IR loads on the strobe or on a fetch while running.
    always_comb begin
        strobe_o     = (state_q == CH_START);
        run_o        = (state_q == CH_RUN);
        ir_load_o    = strobe_o || (run_o && instr_fetch_i);
        entry_addr_o = entry_q;
    end

endmodule

// File: rtl/seq_launcher.sv
// Module: seq_launcher (top)
// Run-control sequence launcher: synchroniser, pending register, priority
// encoder and start chain.
// Assumes: NUM_REQ <= 2**IDX_W and ENTRY_BASE low IDX_W bits are don't-care.
module seq_launcher #(
    parameter int                 NUM_REQ     = 4,
    parameter int                 SYNC_STAGES = 2,
    parameter int                 UADDR_W     = 10,
    parameter logic [UADDR_W-1:0] ENTRY_BASE  = 10'h300
) (
    input  logic               clk_i,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] seq_req_i,
    input  logic               halt_i,
    input  logic               instr_fetch_i,
    output logic [UADDR_W-1:0] entry_addr_o,
    output logic               start_strobe_o,
    output logic               ir_load_o,
    output logic               run_o
);

    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    logic [NUM_REQ-1:0] req_sync;
    logic [NUM_REQ-1:0] pending;
    logic [NUM_REQ-1:0] grant;
    logic [IDX_W-1:0]   win_idx;
    logic               win_valid;
    logic               chain_idle;
    logic               chain_launch;

    seq_req_sync #(
        .NUM_REQ    (NUM_REQ),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i      (clk_i),
        .rst_n      (rst_n),
        .req_async_i(seq_req_i),
        .req_sync_o (req_sync)
    );

    seq_req_hold #(
        .NUM_REQ(NUM_REQ)
    ) u_hold (
        .clk_i     (clk_i),
        .rst_n     (rst_n),
        .req_sync_i(req_sync),
        .accept_i  (chain_idle),
        .launch_i  (chain_launch),
        .grant_i   (grant),
        .pending_o (pending)
    );

    seq_prio_enc #(
        .NUM_REQ(NUM_REQ),
        .IDX_W  (IDX_W)
    ) u_prio (
        .pending_i(pending),
        .valid_o  (win_valid),
        .idx_o    (win_idx),
        .grant_o  (grant)
    );

    seq_start_chain #(
        .IDX_W     (IDX_W),
        .UADDR_W   (UADDR_W),
        .ENTRY_BASE(ENTRY_BASE)
    ) u_chain (
        .clk_i        (clk_i),
        .rst_n        (rst_n),
        .valid_i      (win_valid),
        .idx_i        (win_idx),
        .halt_i       (halt_i),
        .instr_fetch_i(instr_fetch_i),
        .idle_o       (chain_idle),
        .launch_o     (chain_launch),
        .entry_addr_o (entry_addr_o),
        .strobe_o     (start_strobe_o),
        .run_o        (run_o),
        .ir_load_o    (ir_load_o)
    );

endmodule

// File: rtl/seq_launcher_checker.sv
// Module: seq_launcher_checker
// Temporal checks on the launcher ports, bound into every seq_launcher.
module seq_launcher_checker #(
    parameter int UADDR_W = 10
) (
    input logic               clk_i,
    input logic               rst_n,
    input logic               halt_i,
    input logic               instr_fetch_i,
    input logic [UADDR_W-1:0] entry_addr_o,
    input logic               start_strobe_o,
    input logic               ir_load_o,
    input logic               run_o
);

    assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
        start_strobe_o |=> !start_strobe_o);

    assert_strobe_then_run_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
        (start_strobe_o && !halt_i) |=> run_o);

    assert_no_overlap_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
        !(start_strobe_o && run_o));

    assert_run_after_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
        $rose(run_o) |-> $past(start_strobe_o));

    assert_halt_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
        (run_o && halt_i) |=> !run_o);

    assert_halt_in_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
        (start_strobe_o && halt_i) |=> !run_o);

    assert_ir_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
        (ir_load_o && !start_strobe_o) |-> (run_o && instr_fetch_i));

    assert_entry_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
        !$stable(entry_addr_o) |-> start_strobe_o);

endmodule

bind seq_launcher seq_launcher_checker #(.UADDR_W(UADDR_W)) u_checker (
    .clk_i         (clk_i),
    .rst_n         (rst_n),
    .halt_i        (halt_i),
    .instr_fetch_i (instr_fetch_i),
    .entry_addr_o  (entry_addr_o),
    .start_strobe_o(start_strobe_o),
    .ir_load_o     (ir_load_o),
    .run_o         (run_o)
);

// File: tb/seq_launcher_bench.sv
// Directed bench for seq_launcher; one task per scenario.
module seq_launcher_bench;

    localparam int NREQ  = 4;
    localparam int SYNC  = 2;
    localparam int AW    = 10;
    localparam int BASE  = 'h300;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NREQ-1:0] req = '0;
    logic            halt = 1'b0;
    logic            fetch = 1'b0;
    logic [AW-1:0]   entry;
    logic            strobe;
    logic            irld;
    logic            run;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    seq_launcher #(
        .NUM_REQ(NREQ), .SYNC_STAGES(SYNC), .UADDR_W(AW), .ENTRY_BASE(10'h300)
    ) u_seq_launcher (
        .clk_i(clk), .rst_n(rst_n), .seq_req_i(req), .halt_i(halt),
        .instr_fetch_i(fetch), .entry_addr_o(entry), .start_strobe_o(strobe),
        .ir_load_o(irld), .run_o(run)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req_tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req_tag, what, act, exp);
        end
    endtask

    // One-cycle request pulse, then wait until just before the strobe edge.
    task automatic pulse_req(input logic [NREQ-1:0] bits);
        req = bits;
        tick(1);
        req = '0;
        tick(SYNC);
    endtask

    // Halt for one edge.
    task automatic do_halt();
        halt = 1'b1;
        tick(1);
        halt = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        chk("R1", "strobe", int'(strobe), 0);
        chk("R1", "run", int'(run), 0);
        chk("R1", "ir_load", int'(irld), 0);
        chk("R1", "entry", int'(entry), 0);
        rst_n = 1'b1;
        tick(1);
    endtask

    // All four at once: drain 0,1,2,3 in order.
    task automatic t_priority_drain();
        pulse_req(4'b1111);
        chk("R2", "strobe early", int'(strobe), 0);
        tick(1);
        chk("R2", "strobe on time", int'(strobe), 1);
        chk("R3", "entry idx0", int'(entry), BASE + 0);
        chk("R8", "ir_load in strobe", int'(irld), 1);
        tick(1);
        chk("R4", "strobe one cycle", int'(strobe), 0);
        chk("R4", "run set", int'(run), 1);
        for (int k = 1; k < 4; k++) begin
            do_halt();
            chk("R7", "run cleared", int'(run), 0);
            tick(1);
            chk("R5", "next strobe", int'(strobe), 1);
            chk("R5", "next entry", int'(entry), BASE + k);
            tick(1);
        end
        do_halt();
        tick(3);
        chk("R5", "all drained", int'(strobe | run), 0);
    endtask

    // Two requests, higher priority wins, other launches after halt.
    task automatic t_pair();
        pulse_req(4'b1010);
        tick(1);
        chk("R3", "entry idx1", int'(entry), BASE + 1);
        tick(1);
        do_halt();
        tick(1);
        chk("R5", "entry idx3", int'(entry), BASE + 3);
        tick(1);
        do_halt();
    endtask

    // Requests during RUN are dropped; entry holds.
    task automatic t_ignore_running();
        pulse_req(4'b0100);
        tick(2);
        chk("R4", "running", int'(run), 1);
        req = 4'b0001;
        tick(1);
        req = '0;
        tick(5);
        do_halt();
        for (int k = 0; k < 6; k++) begin
            tick(1);
            chk("R6", "no late launch", int'(strobe | run), 0);
        end
        chk("R9", "entry held", int'(entry), BASE + 2);
    endtask

    // Halt during strobe prevents RUN.
    task automatic t_halt_in_strobe();
        pulse_req(4'b0010);
        tick(1);
        chk("R4", "strobe", int'(strobe), 1);
        do_halt();
        chk("R7", "no run after halted strobe", int'(run), 0);
        tick(1);
        chk("R7", "still idle", int'(run | strobe), 0);
    endtask

    // Fetch gating by RUN.
    task automatic t_ir_gating();
        fetch = 1'b1;
        #1;
        chk("R8", "idle fetch ignored", int'(irld), 0);
        fetch = 1'b0;
        pulse_req(4'b0001);
        tick(2);
        chk("R8", "run no fetch", int'(irld), 0);
        fetch = 1'b1;
        #1;
        chk("R8", "run fetch", int'(irld), 1);
        fetch = 1'b0;
        do_halt();
        tick(1);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_priority_drain();
        t_pair();
        t_ignore_running();
        t_halt_in_strobe();
        t_ir_gating();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule